// File: doc/BRIEF.md
# Normalizing Barrel Shifter

This block is a registered shifter for 16-bit fixed-point words. It does plain logical and arithmetic shifts. It also covers the steps used for floating-point style scaling: it finds how many redundant sign bits a word carries, normalizes a word by removing them, and denormalizes a word with a right shift by a given exponent. A block mode keeps a running exponent over a stream of words, so that a whole array can later be rescaled by one common amount as block floating point.

Each request is a 16-bit word, a signed shift amount and an operation code. The word is first placed into the upper or the lower half of a 32-bit field, and the shift then acts on that field. The result appears one clock later as two 16-bit halves, together with a signed exponent.

Top module: `nbs_top`

## Requirements
- R1: While reset is asserted and after it is released, `valid_out` is 0, `res_hi`, `res_lo` and `exp_out` are 0, and the stored block exponent is -15 (all headroom).
- R2: A request with `valid_in` high produces its result on the outputs at the next rising edge, with `valid_out` high for that one cycle. While `valid_in` is low, `valid_out` is 0 and the result and exponent outputs hold their values.
- R3: With `hi_sel`=1 the word is placed in bits 31:16 and bits 15:0 are zero. With `hi_sel`=0 the word is placed in bits 15:0. The bits above it are zero for the logical shift and copies of the word's bit 15 for every other operation.
- R4: Operation code 0 is the logical shift. A positive `amt` shifts left and a negative `amt` shifts right, with zeros filling in both directions. A magnitude of 32 or more gives zero. `exp_out` is 0.
- R5: Operation code 1 is the arithmetic shift. A left shift fills with zeros. A right shift fills with copies of bit 31 of the placed field. A right magnitude of 32 or more gives 32 copies of that bit, and a left magnitude of 32 or more gives zero. `exp_out` is 0.
- R6: Operation code 2 derives the exponent. Let n be the number of bits directly below bit 15, counted downward from bit 14, that equal bit 15 before the first bit that differs. `exp_out` is -n, so 0x0000 and 0xFFFF report -15. Both result halves are 0.
- R7: Operation code 3 normalizes. The placed field is shifted left by n, where n is the count of R6, and `exp_out` is -n. With `hi_sel`=1 and an input other than 0x0000 or 0xFFFF, bits 31 and 30 of the result differ.
- R8: Operation code 4 denormalizes. The placed field is shifted right arithmetically by the magnitude of `amt`, whatever its sign, and a magnitude of 32 or more gives copies of bit 31. `exp_out` is 0.
- R9: Operation code 5 is the block step. The stored block exponent becomes the larger of itself and -n of the current word, which keeps the smallest headroom seen since reset. `exp_out` shows the updated value and both result halves are 0. No other operation changes the stored block exponent.
- R10: Operation codes 6 and 7 return zero in both halves and 0 on `exp_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| hi_sel | input | 1 | 1 places the word in the upper half, 0 in the lower half |
| din | input | 16 | Input word |
| amt | input | 7 | Signed shift amount or exponent |
| valid_out | output | 1 | Result strobe, one cycle after the request |
| res_hi | output | 16 | Result bits 31:16 |
| res_lo | output | 16 | Result bits 15:0 |
| exp_out | output | 7 | Signed exponent or block exponent |

## Verification
The shift path has no state, so an error in a stage select, in the fill bit or in the saturation shows up in the very next result for the amounts that reach it. Random amounts near ±32 and the all-zero and all-one words expose such errors. The stored block exponent is the only state that lives across requests. A wrong update is hidden until the next block step, which is why every block run ends with a 0x0000 word: that word reads back the stored value unchanged, after other operations have come in between. An error in the sign-bit counter shows up at once on both the derive and normalize results.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

   typedef enum logic [2:0] {
      OP_LSH    = 3'd0,
      OP_ASH    = 3'd1,
      OP_EXP    = 3'd2,
      OP_NORM   = 3'd3,
      OP_DENORM = 3'd4,
      OP_BLK    = 3'd5
   } nbs_op_e;

endpackage

// File: rtl/nbs_lead.sv
// Counts sign bits that repeat below the MSB (redundant sign bits).
module nbs_lead #(
   parameter int W = 16,
   localparam int CW = $clog2(W) + 1
) (
   input  logic [W-1:0]  din,
   output logic [CW-1:0] cnt
);

   generate
      if (W < 4) begin : g_bad_w
         $error("nbs_lead: W must be at least 4");
      end
   endgenerate

   always_comb begin
      logic run;
      cnt = '0;
      run = 1'b1;
      for (int i = W - 2; i >= 0; i--) begin
         if (run && (din[i] == din[W-1])) cnt = cnt + 1'b1;
         else                             run = 1'b0;
      end
   end

endmodule

// File: rtl/nbs_shift.sv
// Bidirectional shifter with selectable fill and saturation for large amounts.
module nbs_shift #(
   parameter int W      = 32,
   parameter int MAG_W  = 7,
   parameter bit STAGED = 1'b1,
   localparam int ST    = $clog2(W)
) (
   input  logic [W-1:0]     data,
   input  logic             left,
   input  logic             fill,
   input  logic [MAG_W-1:0] mag,
   output logic [W-1:0]     dout
);

   generate
      if (MAG_W <= ST) begin : g_bad_mag
         $error("nbs_shift: MAG_W must exceed log2(W)");
      end
      if ((1 << ST) != W) begin : g_bad_pow
         $error("nbs_shift: W must be a power of two");
      end
   endgenerate

   logic [W-1:0] core;
   logic         over;

   assign over = |mag[MAG_W-1:ST];

   generate
      if (STAGED) begin : g_log
         logic [W-1:0] stg [0:ST];
         assign stg[0] = data;
         for (genvar i = 0; i < ST; i++) begin : g_stage
            localparam int K = 1 << i;
            assign stg[i+1] = !mag[i] ? stg[i]
                            : left    ? {stg[i][W-1-K:0], {K{1'b0}}}
                            :           {{K{fill}}, stg[i][W-1:K]};
         end
         assign core = stg[ST];
      end else begin : g_flat
         logic [2*W-1:0] wide;
         assign wide = {{W{fill}}, data} >> mag[ST-1:0];
         assign core = left ? (data << mag[ST-1:0]) : wide[W-1:0];
      end
   endgenerate

   assign dout = over ? (left ? '0 : {W{fill}}) : core;

   always_comb begin
      if (mag == '0) begin
         assert_zero_amount_identity_R4 : assert (dout == data);
      end
   end

endmodule

// File: rtl/nbs_top.sv
module nbs_top
   import nbs_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int SH_W   = 7,
   parameter bit STAGED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_in,
   input  logic [2:0]        op,
   input  logic              hi_sel,
   input  logic [DATA_W-1:0] din,
   input  logic [SH_W-1:0]   amt,
   output logic              valid_out,
   output logic [DATA_W-1:0] res_hi,
   output logic [DATA_W-1:0] res_lo,
   output logic [SH_W-1:0]   exp_out
);

   localparam int RES_W = 2 * DATA_W;
   localparam int CW    = $clog2(DATA_W) + 1;
   localparam logic signed [SH_W-1:0] BLK_INIT = -SH_W'(DATA_W - 1);

   generate
      if ((1 << (SH_W - 1)) < RES_W) begin : g_bad_sh
         $error("nbs_top: SH_W too narrow for a full-width shift amount");
      end
   endgenerate

   nbs_op_e op_e;
   assign op_e = nbs_op_e'(op);

   // placement of the word into the wide field
   logic             arith;
   logic [RES_W-1:0] placed;
   assign arith  = (op_e != OP_LSH);
   assign placed = hi_sel ? {din, {DATA_W{1'b0}}}
                          : {(arith ? {DATA_W{din[DATA_W-1]}} : {DATA_W{1'b0}}), din};

   // redundant sign count and exponent
   logic [CW-1:0]          rsb;
   logic signed [SH_W-1:0] exp_now;
   nbs_lead #(.W(DATA_W)) u_lead (.din(din), .cnt(rsb));
   assign exp_now = -$signed(SH_W'(rsb));

   // shift control
   logic            amt_neg;
   logic [SH_W-1:0] amt_mag;
   logic            sh_left, sh_fill;
   logic [SH_W-1:0] sh_mag;
   logic [RES_W-1:0] sh_out;

   assign amt_neg = amt[SH_W-1];
   assign amt_mag = amt_neg ? (~amt + 1'b1) : amt;

   always_comb begin
      sh_left = 1'b1;
      sh_fill = 1'b0;
      sh_mag  = '0;
      unique case (op_e)
         OP_LSH: begin
            sh_left = !amt_neg;
            sh_mag  = amt_mag;
         end
         OP_ASH: begin
            sh_left = !amt_neg;
            sh_fill = amt_neg & placed[RES_W-1];
            sh_mag  = amt_mag;
         end
         OP_NORM: begin
            sh_mag  = SH_W'(rsb);
         end
         OP_DENORM: begin
            sh_left = 1'b0;
            sh_fill = placed[RES_W-1];
            sh_mag  = amt_mag;
         end
         default: ;
      endcase
   end

   nbs_shift #(.W(RES_W), .MAG_W(SH_W), .STAGED(STAGED)) u_shift (
      .data(placed), .left(sh_left), .fill(sh_fill), .mag(sh_mag), .dout(sh_out)
   );

   // block exponent
   logic signed [SH_W-1:0] blk_q, blk_d;
   assign blk_d = (exp_now > blk_q) ? exp_now : blk_q;

   logic [RES_W-1:0] res_d;
   logic [SH_W-1:0]  exp_d;
   always_comb begin
      res_d = '0;
      exp_d = '0;
      case (op_e)
         OP_LSH, OP_ASH, OP_DENORM: res_d = sh_out;
         OP_NORM: begin
            res_d = sh_out;
            exp_d = exp_now;
         end
         OP_EXP: exp_d = exp_now;
         OP_BLK: exp_d = blk_d;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_out <= 1'b0;
         res_hi    <= '0;
         res_lo    <= '0;
         exp_out   <= '0;
         blk_q     <= BLK_INIT;
      end else begin
         valid_out <= valid_in;
         if (valid_in) begin
            res_hi  <= res_d[RES_W-1:DATA_W];
            res_lo  <= res_d[DATA_W-1:0];
            exp_out <= exp_d;
            if (op_e == OP_BLK) blk_q <= blk_d;
         end
      end
   end

   // assertions
   assert_strobe_follows_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> valid_out);
   assert_idle_holds_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> (!valid_out && $stable(res_hi) && $stable(res_lo) && $stable(exp_out)));
   assert_lsh_zero_pass_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && op == 3'd0 && hi_sel && amt == '0) |=> (res_hi == $past(din) && res_lo == '0));
   assert_norm_leading_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && op == 3'd3 && hi_sel && din != '0 && din != '1)
      |=> (res_hi[DATA_W-1] != res_hi[DATA_W-2]));
   assert_blk_never_falls_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      blk_q >= $past(blk_q));
   assert_spare_codes_zero_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && op[2:1] == 2'b11) |=> (res_hi == '0 && res_lo == '0 && exp_out == '0));

endmodule

// File: tb/tb_nbs_top.sv
module tb_nbs_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_in = 1'b0;
   logic [2:0]  op = '0;
   logic        hi_sel = 1'b0;
   logic [15:0] din = '0;
   logic [6:0]  amt = '0;
   logic        valid_out;
   logic [15:0] res_hi, res_lo;
   logic [6:0]  exp_out;

   nbs_top dut (.*);

   always #10 clk = ~clk;   // 50 MHz

   int nvec = 0;
   int nbad = 0;
   bit done = 1'b0;

   // reference state
   logic        e_valid = 1'b0;
   logic [31:0] e_res = '0;
   int          e_exp = 0;
   int          blk = -15;
   string       e_tag = "R1";

   function automatic int rsb(input logic [15:0] d);
      int k = 0;
      while (k < 15 && d[14-k] == d[15]) k++;
      return k;
   endfunction

   function automatic logic [31:0] sar(input logic [31:0] p, input int m);
      if (m >= 32) return {32{p[31]}};
      return 32'($signed(p) >>> m);
   endfunction

   task automatic compare();
      nvec++;
      if (valid_out !== e_valid || {res_hi, res_lo} !== e_res ||
          $signed(exp_out) != e_exp) begin
         nbad++;
         $display("FAIL %s: got v=%0b res=%h exp=%0d, expected v=%0b res=%h exp=%0d",
                  e_tag, valid_out, {res_hi, res_lo}, $signed(exp_out),
                  e_valid, e_res, e_exp);
      end
   endtask

   // one clock: check previous expectation, drive next request, update model
   task automatic step(input bit v, input int o, input bit h,
                       input logic [15:0] d, input int a);
      logic [31:0] p;
      int m;
      @(negedge clk);
      compare();
      valid_in = v; op = 3'(o); hi_sel = h; din = d; amt = 7'(a);
      e_valid = v;
      if (!v) begin
         e_tag = "R2";
         return;
      end
      p = h ? {d, 16'h0} : {((o != 0) ? {16{d[15]}} : 16'h0), d};
      m = (a < 0) ? -a : a;
      e_exp = 0;
      case (o)
         0: begin
            e_tag = "R4,R3";
            if (m >= 32) e_res = '0;
            else e_res = (a >= 0) ? (p << m) : (p >> m);
         end
         1: begin
            e_tag = "R5,R3";
            if (a >= 0) e_res = (m >= 32) ? '0 : (p << m);
            else        e_res = sar(p, m);
         end
         2: begin
            e_tag = "R6";
            e_res = '0; e_exp = -rsb(d);
         end
         3: begin
            e_tag = "R7,R3";
            e_res = p << rsb(d); e_exp = -rsb(d);
         end
         4: begin
            e_tag = "R8,R3";
            e_res = sar(p, m);
         end
         5: begin
            e_tag = "R9";
            if (-rsb(d) > blk) blk = -rsb(d);
            e_res = '0; e_exp = blk;
         end
         default: begin
            e_tag = "R10";
            e_res = '0;
         end
      endcase
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin : stim
      // R1 reset state
      repeat (3) @(negedge clk);
      e_tag = "R1"; compare();
      rst_n = 1'b1;
      e_tag = "R1";
      step(0, 0, 0, 16'h0, 0);
      // R9 reset value seen through block op with an all-zero word
      step(1, 5, 0, 16'h0000, 0);
      // directed placement and shift edges (R3 R4 R5 R8)
      step(1, 0, 1, 16'h8001, 0);
      step(1, 0, 0, 16'h8001, 16);
      step(1, 0, 1, 16'hFFFF, -32);
      step(1, 0, 1, 16'hFFFF, 32);
      step(1, 0, 0, 16'h8421, -31);
      step(1, 1, 0, 16'h8000, -4);
      step(1, 1, 1, 16'h8000, -32);
      step(1, 1, 1, 16'h8000, -64);
      step(1, 1, 0, 16'h1234, 33);
      step(1, 4, 0, 16'hF000, 5);
      step(1, 4, 1, 16'h7FFF, -40);
      step(1, 4, 1, 16'h9000, 0);
      // R6 R7 corner words
      step(1, 2, 0, 16'h0000, 0);
      step(1, 2, 0, 16'hFFFF, 0);
      step(1, 2, 0, 16'h8000, 0);
      step(1, 2, 0, 16'h4000, 0);
      step(1, 2, 0, 16'h0001, 0);
      step(1, 3, 1, 16'h0001, 0);
      step(1, 3, 0, 16'hFFFE, 0);
      step(1, 3, 1, 16'h0000, 0);
      // R10 spare codes
      step(1, 6, 1, 16'h5555, 3);
      step(1, 7, 0, 16'hAAAA, -3);
      // R2 idle cycles hold outputs
      step(0, 0, 1, 16'hFFFF, 5);
      step(0, 3, 0, 16'h1234, -5);
      // R9 block run, then other ops, then read back with zero word
      step(1, 5, 0, 16'h0030, 0);
      step(1, 5, 0, 16'h0100, 0);
      step(1, 5, 0, 16'hFFF0, 0);
      step(1, 2, 0, 16'h4000, 0);
      step(1, 3, 1, 16'h4000, 0);
      step(1, 5, 0, 16'h0000, 0);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         int o, a;
         bit v;
         logic [15:0] d;
         v = ($urandom_range(7) != 0);
         o = $urandom_range(7);
         a = int'($urandom_range(84)) - 42;
         case ($urandom_range(3))
            0: d = 16'($urandom_range(65535));
            1: d = 16'(1 << $urandom_range(15));
            2: d = ~16'(1 << $urandom_range(15));
            default: d = {16{1'b0}} | 16'($urandom_range(3));
         endcase
         step(v, o, $urandom_range(1) == 1, d, a);
      end
      step(1, 5, 0, 16'h0000, 0);
      step(0, 0, 0, 16'h0, 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule